// File: doc/BRIEF.md
# Link Mode Resolver for Speed/Duplex Negotiation

This block picks the operating speed and duplex of a twisted-pair Ethernet port. There are three possible sources for the result. When negotiation is enabled and the link partner's ability word has arrived, the block compares it with the local ability word. It then takes the best mode that both ends support. When negotiation is enabled but no partner word has arrived, the block can fall back on a parallel-detection result, meaning the line signal type seen at the receiver. When negotiation is disabled, it drives the forced speed and duplex taken from the control bits.

The result is held in a register. A one-cycle `res_valid` pulse marks each change of the resolved mode. A separate flag reports that the two ability words share no mode. Generating link pulses and exchanging pages are handled elsewhere. This block only consumes their outcome.

Top module: `an_mode_resolver`

## Requirements
- R1: Ability words use bit 0 = 10 Mb/s half, bit 1 = 10 Mb/s full, bit 2 = 100 Mb/s half, bit 3 = 100 Mb/s full. The preference from best to worst is bit 3, bit 2, bit 1, bit 0.
- R2: When negotiation is enabled and `partner_valid` is high, the chosen mode is the most preferred bit that is set in both `local_abil` and `partner_abil`.
- R3: Negotiation counts as enabled when either `strap_an_en` or `ctl_an_en` is high.
- R4: When negotiation is disabled, the result is `ctl_force_100` (1 = 100 Mb/s) and `ctl_force_full` (1 = full duplex). The ability words and the detection inputs have no effect.
- R5: When negotiation is enabled, `partner_valid` is low and `pd_valid` is high, the result is half duplex at the speed given by `pd_is_100`.
- R6: When `partner_valid` and `pd_valid` are both high, the ability words decide and the detection result is ignored.
- R7: When negotiation is enabled, `partner_valid` is high and the two ability words share no bit, `no_common` is high one cycle later. In that case `res_valid` stays low and the previous mode is kept.
- R8: Outputs are registered and follow their inputs with one clock of latency. `res_valid` is high for exactly the cycle in which a new mode appears: the first mode after reset, or a mode different from the one held. It stays low while the mode is unchanged.
- R9: When negotiation is enabled and neither `partner_valid` nor `pd_valid` is high, the held mode stays, `no_common` is low and `res_valid` is low.
- R10: During reset and after it, until the first mode is resolved, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_an_en | input | 1 | Negotiation enable from the strap |
| ctl_an_en | input | 1 | Negotiation enable from the control bit |
| ctl_force_100 | input | 1 | Forced speed, 1 = 100 Mb/s |
| ctl_force_full | input | 1 | Forced duplex, 1 = full |
| local_abil | input | 4 | Local ability word |
| partner_abil | input | 4 | Partner ability word |
| partner_valid | input | 1 | Partner ability word has been received |
| pd_valid | input | 1 | Parallel-detection result is present |
| pd_is_100 | input | 1 | Detected line speed, 1 = 100 Mb/s |
| res_is_100 | output | 1 | Resolved speed, 1 = 100 Mb/s |
| res_full | output | 1 | Resolved duplex, 1 = full |
| res_valid | output | 1 | One-cycle pulse on a new resolved mode |
| no_common | output | 1 | Ability words share no mode |

## Verification
A partner word and a parallel-detection result can both be present in the same cycle. Equally, an empty intersection can arrive in the very cycle a detection result is waiting. The bench provokes both by sweeping every combination of the enable, forced, valid and detect inputs against all 256 pairs of ability words. A reference model in the bench decides whether the partner word wins, or whether `no_common` should rise with no pulse. The model also tracks the held mode, so that the pulse and the kept mode are checked one cycle later on every vector.

// File: rtl/anr_pkg.sv
package anr_pkg;

   localparam int unsigned ANR_TECH_W = 4;
   localparam int unsigned ANR_IDX_W  = $clog2(ANR_TECH_W);

   typedef struct packed {
      logic spd100;
      logic full;
   } anr_mode_t;

   typedef enum logic [1:0] {
      ANR_SRC_NONE   = 2'd0,
      ANR_SRC_FORCED = 2'd1,
      ANR_SRC_NEG    = 2'd2,
      ANR_SRC_PD     = 2'd3
   } anr_src_e;

   // The ability bit index doubles as the mode code {speed, duplex}.
   function automatic anr_mode_t anr_mode_of_idx(input logic [ANR_IDX_W-1:0] idx);
      anr_mode_t m;
      m.spd100 = idx[1];
      m.full   = idx[0];
      return m;
   endfunction

endpackage

// File: rtl/anr_pick.sv
module anr_pick #(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned IMPL  = 0,
   localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   if (WIDTH < 2) begin : g_bad_width
      $error("anr_pick: WIDTH must be at least 2");
   end
   if (IMPL > 1) begin : g_bad_impl
      $error("anr_pick: IMPL must be 0 or 1");
   end

   assign any = |req;

   if (IMPL == 0) begin : g_scan
      // Linear scan: the highest set bit is the last one written.
      always_comb begin
         idx = '0;
         for (int i = 0; i < WIDTH; i++) begin
            if (req[i]) idx = IDX_W'(i);
         end
      end
   end else begin : g_chain
      // Mask chain: one-hot of the top set bit, then an OR encoder.
      logic [WIDTH-1:0] above;
      logic [WIDTH-1:0] onehot;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (i == WIDTH - 1) begin : g_top
            assign above[i] = 1'b0;
         end else begin : g_low
            assign above[i] = above[i+1] | req[i+1];
         end
         assign onehot[i] = req[i] & ~above[i];
      end
      always_comb begin
         idx = '0;
         for (int i = 0; i < WIDTH; i++) begin
            if (onehot[i]) idx = idx | IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/anr_source_sel.sv
module anr_source_sel
   import anr_pkg::*;
(
   input  logic      an_en,
   input  logic      partner_valid,
   input  logic      pd_valid,
   input  logic      pd_is_100,
   input  anr_mode_t forced_mode,
   input  logic      neg_any,
   input  anr_mode_t neg_mode,
   output logic      cand_ok,
   output anr_mode_t cand_mode,
   output logic      cand_nocommon,
   output anr_src_e  cand_src
);

   always_comb begin
      cand_ok       = 1'b0;
      cand_mode     = '0;
      cand_nocommon = 1'b0;
      cand_src      = ANR_SRC_NONE;
      if (!an_en) begin
         cand_ok   = 1'b1;
         cand_mode = forced_mode;
         cand_src  = ANR_SRC_FORCED;
      end else if (partner_valid) begin
         cand_src = ANR_SRC_NEG;
         if (neg_any) begin
            cand_ok   = 1'b1;
            cand_mode = neg_mode;
         end else begin
            cand_nocommon = 1'b1;
         end
      end else if (pd_valid) begin
         cand_ok          = 1'b1;
         cand_mode.spd100 = pd_is_100;
         cand_mode.full   = 1'b0;
         cand_src         = ANR_SRC_PD;
      end
   end

endmodule

// File: rtl/anr_result_reg.sv
module anr_result_reg
   import anr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cand_ok,
   input  anr_mode_t cand_mode,
   input  logic      cand_nocommon,
   output anr_mode_t mode_q,
   output logic      valid_q,
   output logic      nocommon_q
);

   logic held_q;
   logic take;

   assign take = cand_ok && (!held_q || (cand_mode != mode_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q     <= '0;
         held_q     <= 1'b0;
         valid_q    <= 1'b0;
         nocommon_q <= 1'b0;
      end else begin
         nocommon_q <= cand_nocommon;
         valid_q    <= take;
         if (take) begin
            mode_q <= cand_mode;
            held_q <= 1'b1;
         end
      end
   end

   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q |-> $stable(mode_q)); // R8

   AST_NOCOMMON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      nocommon_q |-> !valid_q); // R7

endmodule

// File: rtl/an_mode_resolver.sv
module an_mode_resolver
   import anr_pkg::*;
#(
   parameter int unsigned PICK_IMPL = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strap_an_en,
   input  logic       ctl_an_en,
   input  logic       ctl_force_100,
   input  logic       ctl_force_full,
   input  logic [3:0] local_abil,
   input  logic [3:0] partner_abil,
   input  logic       partner_valid,
   input  logic       pd_valid,
   input  logic       pd_is_100,
   output logic       res_is_100,
   output logic       res_full,
   output logic       res_valid,
   output logic       no_common
);

   if (ANR_TECH_W != 4) begin : g_bad_tech
      $error("an_mode_resolver: mode code needs a four-bit ability word");
   end
   if (PICK_IMPL > 1) begin : g_bad_impl
      $error("an_mode_resolver: PICK_IMPL must be 0 or 1");
   end

   logic [ANR_TECH_W-1:0] common;
   logic                  neg_any;
   logic [ANR_IDX_W-1:0]  neg_idx;
   logic                  an_en;
   anr_mode_t             forced_mode;
   anr_mode_t             neg_mode;
   logic                  cand_ok;
   anr_mode_t             cand_mode;
   logic                  cand_nocommon;
   anr_src_e              cand_src;
   anr_mode_t             mode_q;

   assign an_en              = strap_an_en | ctl_an_en;
   assign common             = local_abil & partner_abil;
   assign forced_mode.spd100 = ctl_force_100;
   assign forced_mode.full   = ctl_force_full;
   assign neg_mode           = anr_mode_of_idx(neg_idx);

   anr_pick #(
      .WIDTH (ANR_TECH_W),
      .IMPL  (PICK_IMPL)
   ) pick_i (
      .req (common),
      .any (neg_any),
      .idx (neg_idx)
   );

   anr_source_sel sel_i (
      .an_en         (an_en),
      .partner_valid (partner_valid),
      .pd_valid      (pd_valid),
      .pd_is_100     (pd_is_100),
      .forced_mode   (forced_mode),
      .neg_any       (neg_any),
      .neg_mode      (neg_mode),
      .cand_ok       (cand_ok),
      .cand_mode     (cand_mode),
      .cand_nocommon (cand_nocommon),
      .cand_src      (cand_src)
   );

   anr_result_reg res_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cand_ok       (cand_ok),
      .cand_mode     (cand_mode),
      .cand_nocommon (cand_nocommon),
      .mode_q        (mode_q),
      .valid_q       (res_valid),
      .nocommon_q    (no_common)
   );

   assign res_is_100 = mode_q.spd100;
   assign res_full   = mode_q.full;

   AST_PICK_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
      neg_any |-> ((common >> neg_idx) == 4'd1)); // R1

   AST_NEG_COMMON: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(strap_an_en | ctl_an_en) && $past(partner_valid))
      |-> |($past(local_abil & partner_abil) & (4'd1 << {res_is_100, res_full}))); // R2

   AST_FORCED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !$past(strap_an_en | ctl_an_en))
      |-> ({res_is_100, res_full} == {$past(ctl_force_100), $past(ctl_force_full)})); // R4

   AST_PD_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(strap_an_en | ctl_an_en) && !$past(partner_valid))
      |-> (!res_full && (res_is_100 == $past(pd_is_100)))); // R5

   AST_SRC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      cand_nocommon |-> (cand_src == ANR_SRC_NEG)); // R7

endmodule

// File: tb/an_mode_resolver_tb_top.sv
`timescale 1ns/1ps
module an_mode_resolver_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strap_an_en = 1'b0, ctl_an_en = 1'b0;
   logic       ctl_force_100 = 1'b0, ctl_force_full = 1'b0;
   logic [3:0] local_abil = 4'd0, partner_abil = 4'd0;
   logic       partner_valid = 1'b0, pd_valid = 1'b0, pd_is_100 = 1'b0;
   logic       res_is_100, res_full, res_valid, no_common;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   bit          done = 1'b0;

   // expected held state (model)
   bit       m_held = 1'b0;
   bit [1:0] m_mode = 2'd0;

   always #2 clk = ~clk;

   an_mode_resolver dut_i (
      .clk(clk), .rst_n(rst_n),
      .strap_an_en(strap_an_en), .ctl_an_en(ctl_an_en),
      .ctl_force_100(ctl_force_100), .ctl_force_full(ctl_force_full),
      .local_abil(local_abil), .partner_abil(partner_abil),
      .partner_valid(partner_valid), .pd_valid(pd_valid), .pd_is_100(pd_is_100),
      .res_is_100(res_is_100), .res_full(res_full),
      .res_valid(res_valid), .no_common(no_common)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // One vector: drive, let one edge pass, compare to the model.
   task automatic apply(input bit se, input bit ce, input bit f100, input bit ffull,
                        input bit [3:0] la, input bit [3:0] pa,
                        input bit pv, input bit pdv, input bit pd100);
      bit       en, ok, nc;
      bit [1:0] cm;
      bit [3:0] com;
      bit       e_valid;
      string    tag;
      strap_an_en = se; ctl_an_en = ce;
      ctl_force_100 = f100; ctl_force_full = ffull;
      local_abil = la; partner_abil = pa;
      partner_valid = pv; pd_valid = pdv; pd_is_100 = pd100;
      en = se | ce;                       // R3
      com = la & pa;
      ok = 1'b0; nc = 1'b0; cm = 2'd0;
      if (!en) begin
         ok = 1'b1; cm = {f100, ffull}; tag = "R4";
      end else if (pv) begin
         tag = pdv ? "R6" : "R2";
         if (com[3])      begin ok = 1'b1; cm = 2'd3; end   // R1 order
         else if (com[2]) begin ok = 1'b1; cm = 2'd2; end
         else if (com[1]) begin ok = 1'b1; cm = 2'd1; end
         else if (com[0]) begin ok = 1'b1; cm = 2'd0; end
         else begin nc = 1'b1; tag = "R7"; end
      end else if (pdv) begin
         ok = 1'b1; cm = {pd100, 1'b0}; tag = "R5";
      end else begin
         tag = "R9";
      end
      if (en && (se ^ ce) && tag == "R2") tag = "R3";
      e_valid = ok && (!m_held || cm != m_mode);
      if (e_valid) begin m_mode = cm; m_held = 1'b1; end
      @(posedge clk); #1;
      chk("R8", "res_valid", int'(res_valid), int'(e_valid));
      chk(tag, "res_is_100", int'(res_is_100), int'(m_mode[1]));
      chk(tag, "res_full", int'(res_full), int'(m_mode[0]));
      chk(nc ? "R7" : tag, "no_common", int'(no_common), int'(nc));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R10", "reset res_valid", int'(res_valid), 0);
      chk("R10", "reset res_is_100", int'(res_is_100), 0);
      chk("R10", "reset res_full", int'(res_full), 0);
      chk("R10", "reset no_common", int'(no_common), 0);
      rst_n = 1'b1;
      // nothing to resolve yet: outputs stay at reset values
      apply(1, 0, 1, 1, 4'hF, 4'hF, 0, 0, 1);
      apply(0, 1, 0, 0, 4'h0, 4'h0, 1, 1, 1);   // no common, detect waiting: R7 wins over R5
      // first resolution is forced 10/half (code 0): must still pulse, then stay quiet
      apply(0, 0, 0, 0, 4'h5, 4'hA, 1, 1, 1);
      apply(0, 0, 0, 0, 4'hF, 4'hF, 1, 1, 1);
      // exhaustive sweep
      for (int cfg = 0; cfg < 128; cfg++) begin
         for (int ab = 0; ab < 256; ab++) begin
            apply(cfg[6], cfg[5], cfg[4], cfg[3], ab[7:4], ab[3:0],
                  cfg[2], cfg[1], cfg[0]);
         end
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule